// File: doc/BRIEF.md
# Dual-Rail Zero-Wave Datapath

This block is a small synthesizable datapath in dual-rail, precharge-to-zero logic. Each logical bit travels on a pair of wires, a true rail and a false rail. Every gate is a pair of positive AND/OR networks. The true half computes the function from the true rails. The false half computes the dual function, with AND and OR exchanged, from the false rails. A NOT costs no gate, because it is only a swap of the two rails. The clock has two phases. In the high (precharge) phase, launch stages at the primary inputs and at the register output hold every rail at 0. In the low (evaluation) phase, they pass the pair unchanged. No precharge net reaches the gates: a positive gate whose inputs are all 0 outputs 0, so a wave of zeros runs through the logic on its own. Each pair therefore makes one transition in every cycle, whether or not its logical value changes.

The library gives 2-input AND, OR and XOR, a 2:1 multiplexer, an and-or-invert cell and the rail-swap inverter. It also gives a dual-rail register that has its own launch stage. The example function uses them per bit lane, with a fed-back state bit `s` held in that register. When the lane select is logical 0, the lane computes `a XOR b`. When it is logical 1, it computes `NOT((a AND b) OR s)`. The register captures the lane result at the end of each evaluation phase and shows it on the `q` rails during the next evaluation phase. A registered error flag reports any pair found illegal at the end of an evaluation phase.

Top module: `dr_wave_top`

## Requirements
- R1: In the evaluation phase (clock low), when the select pair of a lane is logical 0 (sel_t=0, sel_f=1), y_t of that lane equals a XOR b of the logical inputs (the true rails).
- R2: In the evaluation phase, when the select pair of a lane is logical 1 (sel_t=1, sel_f=0), y_t of that lane equals NOT((a AND b) OR s), where s is the lane's registered state as shown on q_t.
- R3: In the evaluation phase, with every input pair legal, y_f is the bitwise complement of y_t, so exactly one rail of each output pair is 1.
- R4: In the precharge phase (the clock high phase that follows a rising edge after reset), every rail of y_t, y_f, q_t and q_f is 0, whatever the inputs.
- R5: At each rising clock edge the register captures the y pair that was present at the end of the evaluation phase. During the next evaluation phase, q_t shows the captured true rail and q_f shows its complement.
- R6: While rst_n is low, and in the first evaluation phase after rst_n is released, the state is logical 0 (q_t all 0, q_f all 1) and err is 0.
- R7: err is a registered flag that updates at each rising clock edge. It is 1 after the edge if, at the end of the evaluation phase just ended, any input pair or state pair was illegal (both rails 0 or both rails 1). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock: high is precharge, low is evaluation |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_t | input | W | True rails of operand a |
| a_f | input | W | False rails of operand a |
| b_t | input | W | True rails of operand b |
| b_f | input | W | False rails of operand b |
| sel_t | input | W | True rails of the per-lane select |
| sel_f | input | W | False rails of the per-lane select |
| y_t | output | W | True rails of the lane result |
| y_f | output | W | False rails of the lane result |
| q_t | output | W | True rails of the registered state, after its launch stage |
| q_f | output | W | False rails of the registered state, after its launch stage |
| err | output | 1 | Registered illegal-pair flag |

## Verification
The bench samples inside each half-period. A launch stage that leaks data during precharge fails the zero-rail checks. A false-rail network built with the wrong dual, rather than the De Morgan dual, fails the complement check. The feedback path is driven through several sel=1 cycles in a row, so a register that captures the wrong phase, or a state reset to the wrong polarity, shows up as a wrong q or y value. Pairs are forced to 00 and to 11 to confirm that err rises one edge later and clears after reset. If both rails of a pair are tested with the same polarity, one of these cases is missed.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef struct packed {
    logic t;
    logic f;
  } rail_t;

  typedef enum logic [1:0] { OP2_AND, OP2_OR, OP2_XOR } op2_e;
  typedef enum logic [0:0] { OP3_MUX, OP3_AOI21 } op3_e;

  // positive network on true rails, its dual on false rails
  function automatic rail_t rail_and(rail_t x, rail_t z);
    return '{t: x.t & z.t, f: x.f | z.f};
  endfunction

  function automatic rail_t rail_or(rail_t x, rail_t z);
    return '{t: x.t | z.t, f: x.f & z.f};
  endfunction

  function automatic rail_t rail_xor(rail_t x, rail_t z);
    return '{t: (x.t & z.f) | (x.f & z.t), f: (x.t & z.t) | (x.f & z.f)};
  endfunction

  // s selects d1 when logical 1, d0 when logical 0
  function automatic rail_t rail_mux(rail_t s, rail_t d1, rail_t d0);
    return '{t: (s.t & d1.t) | (s.f & d0.t), f: (s.t & d1.f) | (s.f & d0.f)};
  endfunction

  // NOT((x AND z) OR c): the inversion is the swap at the output
  function automatic rail_t rail_aoi21(rail_t x, rail_t z, rail_t c);
    return '{t: (x.f | z.f) & c.f, f: (x.t & z.t) | c.t};
  endfunction

  function automatic rail_t rail_inv(rail_t x);
    return '{t: x.f, f: x.t};
  endfunction

endpackage

// File: rtl/dr_launch.sv
module dr_launch #(
  parameter int W = 8
) (
  input  logic                      prech,
  input  dr_pkg::rail_t [W-1:0]     d,
  output dr_pkg::rail_t [W-1:0]     o
);
  // both rails low in precharge, pair passed through in evaluation
  always_comb begin
    for (int i = 0; i < W; i++) begin
      o[i].t = d[i].t & ~prech;
      o[i].f = d[i].f & ~prech;
    end
  end
endmodule

// File: rtl/dr_gate2.sv
module dr_gate2 #(
  parameter dr_pkg::op2_e KIND = dr_pkg::OP2_AND
) (
  input  dr_pkg::rail_t x,
  input  dr_pkg::rail_t z,
  output dr_pkg::rail_t y
);
  generate
    case (KIND)
      dr_pkg::OP2_AND: begin : g_and
        assign y = dr_pkg::rail_and(x, z);
      end
      dr_pkg::OP2_OR: begin : g_or
        assign y = dr_pkg::rail_or(x, z);
      end
      default: begin : g_xor
        assign y = dr_pkg::rail_xor(x, z);
      end
    endcase
  endgenerate
endmodule

// File: rtl/dr_gate3.sv
module dr_gate3 #(
  parameter dr_pkg::op3_e KIND = dr_pkg::OP3_MUX
) (
  input  dr_pkg::rail_t x0,
  input  dr_pkg::rail_t x1,
  input  dr_pkg::rail_t x2,
  output dr_pkg::rail_t y
);
  generate
    if (KIND == dr_pkg::OP3_MUX) begin : g_mux
      assign y = dr_pkg::rail_mux(x0, x1, x2);
    end else begin : g_aoi
      assign y = dr_pkg::rail_aoi21(x0, x1, x2);
    end
  endgenerate
endmodule

// File: rtl/dr_reg.sv
module dr_reg #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  prech,
  input  dr_pkg::rail_t [W-1:0] d,
  output dr_pkg::rail_t [W-1:0] st,
  output dr_pkg::rail_t [W-1:0] q
);
  // reset value is logical 0 on every pair
  localparam dr_pkg::rail_t ZERO_PAIR = '{t: 1'b0, f: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= {W{ZERO_PAIR}};
    else        st <= d;
  end

  dr_launch #(.W(W)) u_launch (.prech(prech), .d(st), .o(q));
endmodule

// File: rtl/dr_wave_top.sv
module dr_wave_top #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  input  logic [W-1:0] sel_t,
  input  logic [W-1:0] sel_f,
  output logic [W-1:0] y_t,
  output logic [W-1:0] y_f,
  output logic [W-1:0] q_t,
  output logic [W-1:0] q_f,
  output logic         err
);
  import dr_pkg::*;

  // phase generator: prech is high from a rising edge to the next falling
  // edge, and it comes from flops so that capture at the rising edge sees
  // the evaluated rails rather than the new zeros
  logic ph_hi, ph_lo, prech;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_hi <= 1'b0;
    else        ph_hi <= ~ph_hi;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ph_lo <= 1'b0;
    else        ph_lo <= ph_hi;
  end

  assign prech = ph_hi ^ ph_lo;

  rail_t [W-1:0] a_r, b_r, sel_r, a_l, b_l, sel_l;
  rail_t [W-1:0] st_r, q_r, y_r;
  logic  [W-1:0] s_t, s_f;

  for (genvar i = 0; i < W; i++) begin : g_pack
    assign a_r[i]   = '{t: a_t[i],   f: a_f[i]};
    assign b_r[i]   = '{t: b_t[i],   f: b_f[i]};
    assign sel_r[i] = '{t: sel_t[i], f: sel_f[i]};
  end

  dr_launch #(.W(W)) u_la (.prech(prech), .d(a_r),   .o(a_l));
  dr_launch #(.W(W)) u_lb (.prech(prech), .d(b_r),   .o(b_l));
  dr_launch #(.W(W)) u_ls (.prech(prech), .d(sel_r), .o(sel_l));

  dr_reg #(.W(W)) u_state (
    .clk(clk), .rst_n(rst_n), .prech(prech),
    .d(y_r), .st(st_r), .q(q_r)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    rail_t p_and, p_or, p_not, p_xor;

    dr_gate2 #(.KIND(OP2_AND)) u_and (.x(a_l[i]), .z(b_l[i]), .y(p_and));
    dr_gate2 #(.KIND(OP2_OR))  u_or  (.x(p_and),  .z(q_r[i]), .y(p_or));
    assign p_not = rail_inv(p_or);
    dr_gate2 #(.KIND(OP2_XOR)) u_xor (.x(a_l[i]), .z(b_l[i]), .y(p_xor));
    dr_gate3 #(.KIND(OP3_MUX)) u_mux (.x0(sel_l[i]), .x1(p_not), .x2(p_xor), .y(y_r[i]));

    assign y_t[i] = y_r[i].t;
    assign y_f[i] = y_r[i].f;
    assign q_t[i] = q_r[i].t;
    assign q_f[i] = q_r[i].f;
    assign s_t[i] = st_r[i].t;
    assign s_f[i] = st_r[i].f;
  end

  // legality of every pair that enters the network, and of the result
  logic pairs_ok, y_ok;
  assign pairs_ok = (&(a_t ^ a_f)) & (&(b_t ^ b_f)) & (&(sel_t ^ sel_f)) & (&(s_t ^ s_f));
  assign y_ok     = &(y_t ^ y_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= ~(pairs_ok & y_ok);
  end
endmodule

// File: rtl/dr_wave_chk.sv
module dr_wave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         prech,
  input logic         pairs_ok,
  input logic [W-1:0] y_t,
  input logic [W-1:0] y_f,
  input logic [W-1:0] q_t,
  input logic [W-1:0] q_f,
  input logic [W-1:0] s_t,
  input logic [W-1:0] s_f,
  input logic         err
);
  // R4: values just before the falling edge are those of the precharge phase
  p_prech_zero_r4: assert property (@(negedge clk) disable iff (!rst_n)
    prech |-> ((y_t | y_f | q_t | q_f) == '0));

  // R3: end of evaluation with legal pairs gives complementary outputs
  p_complement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prech && pairs_ok) |-> ((y_t ^ y_f) == '1));

  // R5: the state after an edge is the pair evaluated before it
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !prech |=> (s_t == $past(y_t)) && (s_f == $past(y_f)));

  // R5: in evaluation q shows the held state
  p_q_shows_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !prech |-> (q_t == s_t) && (q_f == s_f));

  // R7: an illegal pair raises the flag one edge later
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prech && !pairs_ok) |=> err);

  // R7: all pairs legal keeps the flag low
  p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!prech && pairs_ok) |=> !err);
endmodule

bind dr_wave_top dr_wave_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .prech(prech), .pairs_ok(pairs_ok),
  .y_t(y_t), .y_f(y_f), .q_t(q_t), .q_f(q_f),
  .s_t(s_t), .s_f(s_f), .err(err)
);

// File: tb/sim_dr_wave_top.sv
`timescale 1ns/1ps
module sim_dr_wave_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t, a_f, b_t, b_f, sel_t, sel_f;
  logic [W-1:0] y_t, y_f, q_t, q_f;
  logic err;

  always #4 clk = ~clk;

  dr_wave_top #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f), .sel_t(sel_t), .sel_f(sel_f),
    .y_t(y_t), .y_f(y_f), .q_t(q_t), .q_f(q_f), .err(err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] s_m = '0;
  bit err_exp = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // lane reference written bit by bit from the requirements
  function automatic logic [W-1:0] lane_ref(logic [W-1:0] a, logic [W-1:0] b,
                                            logic [W-1:0] sel, logic [W-1:0] s);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = sel[i] ? !((a[i] && b[i]) || s[i]) : (a[i] != b[i]);
    return r;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] sel);
    a_t = a;   a_f = ~a;
    b_t = b;   b_f = ~b;
    sel_t = sel; sel_f = ~sel;
  endtask

  // one clock cycle; inj >= 0 forces pair a[inj] to both rails = inj_v
  task automatic cycle(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] sel, input int inj, input bit inj_v);
    logic [W-1:0] e;
    @(posedge clk); #1;
    drive(a, b, sel);
    if (inj >= 0) begin
      a_t[inj] = inj_v;
      a_f[inj] = inj_v;
    end
    #1;
    chk("R4 y rails in precharge", {16'h0, y_t, y_f}, 32'h0);
    chk("R4 q rails in precharge", {16'h0, q_t, q_f}, 32'h0);
    @(negedge clk); #2;
    chk("R7 err flag", {31'h0, err}, {31'h0, err_exp});
    if (inj < 0) begin
      e = lane_ref(a, b, sel, s_m);
      chk("R1 R2 y_t value", {24'h0, y_t}, {24'h0, e});
      chk("R3 y_f complement", {24'h0, y_f}, {24'h0, ~e});
      chk("R5 q_t state", {24'h0, q_t}, {24'h0, s_m});
      chk("R5 q_f state", {24'h0, q_f}, {24'h0, ~s_m});
      s_m = e;
      err_exp = 1'b0;
    end else begin
      err_exp = 1'b1;
    end
  endtask

  task automatic do_reset(input bit look_err);
    @(posedge clk); #1;
    drive('0, '0, '0);
    @(negedge clk); #2;
    if (look_err) chk("R7 err after illegal pair", {31'h0, err}, 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R6 q_t in reset", {24'h0, q_t}, 32'h0);
    chk("R6 q_f in reset", {24'h0, q_f}, 32'hff);
    chk("R6 err in reset", {31'h0, err}, 32'h0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R6 q_t after release", {24'h0, q_t}, 32'h0);
    chk("R6 q_f after release", {24'h0, q_f}, 32'hff);
    chk("R6 err after release", {31'h0, err}, 32'h0);
    s_m = '0;
    err_exp = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2e3f41));
    drive('0, '0, '0);
    do_reset(1'b0);

    // R1 xor path
    cycle(8'h00, 8'h00, 8'h00, -1, 1'b0);
    cycle(8'hff, 8'h00, 8'h00, -1, 1'b0);
    cycle(8'ha5, 8'h3c, 8'h00, -1, 1'b0);
    cycle(8'hff, 8'hff, 8'h00, -1, 1'b0);
    // R2 and-or-invert path through the fed-back state
    cycle(8'h00, 8'h00, 8'hff, -1, 1'b0);
    cycle(8'h00, 8'h00, 8'hff, -1, 1'b0);
    cycle(8'h00, 8'h00, 8'hff, -1, 1'b0);
    cycle(8'hff, 8'hff, 8'hff, -1, 1'b0);
    cycle(8'h0f, 8'hf0, 8'haa, -1, 1'b0);
    cycle(8'h33, 8'h35, 8'h5a, -1, 1'b0);

    for (int k = 0; k < 400; k++)
      cycle($urandom, $urandom, $urandom, -1, 1'b0);

    // R7 illegal pairs: both rails high, then both rails low
    cycle(8'h12, 8'h34, 8'h0f, 3, 1'b1);
    do_reset(1'b1);
    cycle(8'h00, 8'h00, 8'h00, -1, 1'b0);
    cycle(8'h56, 8'h78, 8'hf0, 5, 1'b0);
    do_reset(1'b1);

    for (int k = 0; k < 40; k++)
      cycle($urandom, $urandom, $urandom, -1, 1'b0);

    summary();
    $finish;
  end
endmodule